// File: doc/BRIEF.md
# 64-bit Iterative Integer Multiplier

This unit computes integer products for a 64-bit core's execute stage. A start strobe presents two 64-bit operands and a 3-bit operation code, and the unit captures them. It forms the product over a fixed number of cycles with a radix-2 shift-add datapath. A one-cycle done pulse then marks a valid 64-bit result. The same datapath serves five operations:

- the low half of the product;
- the upper half with both operands signed;
- the upper half with the first operand signed and the second unsigned;
- the upper half with both operands unsigned;
- a 32-bit word product whose result is sign-extended to 64 bits.

Each operand that counts as negative is replaced by its magnitude, and the unsigned product of the magnitudes is accumulated. The 128-bit product is negated when exactly one operand was negative. The wanted half is then selected. The unit accepts a new operation only when it is idle. The caller watches busy, or waits for done, before issuing the next operation.

Top module: `mul64_unit`

## Requirements
- R1: Operation code 0 returns bits 63:0 of the product of a and b, and overflow wraps.
- R2: Operation code 1 treats a and b as two's-complement signed and returns bits 127:64 of the 128-bit product.
- R3: Operation code 2 treats a as signed and b as unsigned and returns bits 127:64 of the 128-bit product.
- R4: Operation code 3 treats a and b as unsigned and returns bits 127:64 of the 128-bit product.
- R5: Operation code 4 multiplies a[31:0] by b[31:0] and keeps the low 32 bits of that product. Bit 31 is copied into result bits 63:32. Bits 63:32 of the operands have no effect.
- R6: A start sampled high at a rising edge while busy is low captures a, b and op. A start sampled while busy is high is ignored, and neither the result nor the done timing of the running operation changes.
- R7: busy goes high at the edge that accepts start. busy goes low, and done goes high, 64 edges later. done stays high for exactly one cycle.
- R8: While reset is held, and until the first done, busy, done and result are 0. result keeps its value from one done pulse until the next.
- R9: Operation codes 5, 6 and 7 behave like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the unit |
| start | input | 1 | Request strobe, sampled when the unit is idle |
| op | input | 3 | Operation code (0 low half, 1 signed high, 2 signed-by-unsigned high, 3 unsigned high, 4 word) |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| busy | output | 1 | High while a product is being formed |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 64 | Selected product bits, held between done pulses |

## Verification
The bench aims at the operands where sign handling breaks:

- **The most negative value times itself.** A unit that negates into a signed 64-bit magnitude would lose this magnitude.
- **The most negative value times minus one.** Here the true product overflows 64 bits. A wrong low-half wrap, or a missing final negation, gives a wrong upper half.
- **Minus one times minus one, and all-ones operands treated as unsigned.** These separate the three high-half variants. A unit that used the wrong signedness for one operand would return all ones or all zeros in the wrong case.
- **Word operations.** Junk is placed in the upper operand bits, and one product has bit 31 set. This exposes a unit that lets the upper bits leak in or that zero-extends the result.
- **Busy and back-to-back operation.** A start pulse during a running operation, and start held high continuously, catch a unit that re-captures operands while busy or that drifts by a cycle in its done timing.

// File: rtl/mul64_pkg.sv
package mul64_pkg;

  typedef enum logic [2:0] {
    OP_LO   = 3'd0,
    OP_HSS  = 3'd1,
    OP_HSU  = 3'd2,
    OP_HUU  = 3'd3,
    OP_WORD = 3'd4
  } mul_op_e;

endpackage

// File: rtl/mul64_prep.sv
// Operand conditioning: picks the operand width, decides which operands count
// as signed, and hands unsigned magnitudes plus a product-sign flag onward.
module mul64_prep
  import mul64_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg
);

  localparam int PADW = XLEN - WLEN;

  logic            is_word;
  logic            sgn_a;
  logic            sgn_b;
  logic [XLEN-1:0] src_a;
  logic [XLEN-1:0] src_b;

  always_comb begin
    is_word = (op == OP_WORD);
    sgn_a   = a[XLEN-1] & ((op == OP_HSS) | (op == OP_HSU));
    sgn_b   = b[XLEN-1] & (op == OP_HSS);
    // Word products only need the low 32 bits, which are sign-agnostic.
    src_a   = is_word ? {{PADW{1'b0}}, a[WLEN-1:0]} : a;
    src_b   = is_word ? {{PADW{1'b0}}, b[WLEN-1:0]} : b;
    // The most negative value maps onto its own bit pattern, which read
    // unsigned is exactly the right magnitude.
    mag_a   = sgn_a ? -src_a : src_a;
    mag_b   = sgn_b ? -src_b : src_b;
    neg     = sgn_a ^ sgn_b;
  end

endmodule

// File: rtl/mul64_core.sv
// Radix-2 shift-add engine: one multiplier bit per cycle, XLEN cycles.
module mul64_core #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XLEN-1:0]   mcand,
  input  logic [XLEN-1:0]   mplier,
  output logic              busy,
  output logic              last,
  output logic [2*XLEN-1:0] prod_next
);

  localparam int PW = 2 * XLEN;
  localparam int CW = $clog2(XLEN + 1);

  logic [PW-1:0]   p_q, p_d;
  logic [XLEN-1:0] mc_q, mc_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            busy_q, busy_d;

  logic [XLEN-1:0] addend;
  logic [XLEN:0]   psum;
  logic [PW-1:0]   p_step;

  always_comb begin
    addend = p_q[0] ? mc_q : '0;
    psum   = {1'b0, p_q[PW-1:XLEN]} + {1'b0, addend};
    p_step = {psum, p_q[XLEN-1:1]};
    last   = busy_q && (cnt_q == CW'(1));
  end

  always_comb begin
    p_d    = p_q;
    mc_d   = mc_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      p_d    = p_step;
      cnt_d  = cnt_q - CW'(1);
      busy_d = !last;
    end else if (load) begin
      p_d    = {{XLEN{1'b0}}, mplier};
      mc_d   = mcand;
      cnt_d  = CW'(XLEN);
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= '0;
      mc_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      p_q    <= p_d;
      mc_q   <= mc_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy      = busy_q;
  assign prod_next = p_step;

  // R7: a run lasts XLEN steps, so the counter starts full and never idles at 0 while busy.
  p_run_starts_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> cnt_q == CW'(XLEN));
  p_cnt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q != '0);
  // R6: the captured multiplicand never moves during a run.
  p_mcand_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(mc_q));

endmodule

// File: rtl/mul64_post.sv
// Sign fix-up of the full product and selection of the requested half.
module mul64_post
  import mul64_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [2:0]        op,
  input  logic              neg,
  input  logic [2*XLEN-1:0] prod,
  output logic [XLEN-1:0]   res
);

  localparam int PW   = 2 * XLEN;
  localparam int PADW = XLEN - WLEN;

  logic [PW-1:0] fixed;

  always_comb begin
    fixed = neg ? -prod : prod;
    case (op)
      OP_HSS, OP_HSU, OP_HUU: res = fixed[PW-1:XLEN];
      OP_WORD:                res = {{PADW{fixed[WLEN-1]}}, fixed[WLEN-1:0]};
      default:                res = fixed[XLEN-1:0];
    endcase
  end

endmodule

// File: rtl/mul64_unit.sv
module mul64_unit
  import mul64_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);

  localparam int PW   = 2 * XLEN;
  localparam int PADW = XLEN - WLEN;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic            core_busy;
  logic            core_last;
  logic            take;
  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_c;
  logic [PW-1:0]   prod_next;
  logic [XLEN-1:0] res_c;

  logic [2:0]      op_q, op_d;
  logic            neg_q, neg_d;
  logic            done_q, done_d;
  logic [XLEN-1:0] result_q, result_d;

  assign take = start && !core_busy;

  mul64_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .op    (op),
    .a     (a),
    .b     (b),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .neg   (neg_c)
  );

  mul64_core #(.XLEN(XLEN)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (take),
    .mcand     (mag_a),
    .mplier    (mag_b),
    .busy      (core_busy),
    .last      (core_last),
    .prod_next (prod_next)
  );

  mul64_post #(.XLEN(XLEN), .WLEN(WLEN)) u_post (
    .op   (op_q),
    .neg  (neg_q),
    .prod (prod_next),
    .res  (res_c)
  );

  always_comb begin
    op_d     = take ? op : op_q;
    neg_d    = take ? neg_c : neg_q;
    done_d   = core_last;
    result_d = core_last ? res_c : result_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      op_q     <= OP_LO;
      neg_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      op_q     <= op_d;
      neg_q    <= neg_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign busy   = core_busy;
  assign done   = done_q;
  assign result = result_q;

  // R7: done is a single-cycle pulse that coincides with the end of busy.
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    done_q |=> !done_q);
  p_done_at_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(core_busy) |-> done_q);
  // R6: a start while busy must not replace the captured operation.
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    core_busy && start |=> $stable(op_q));
  // R8: result only moves on a done pulse.
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !done_q |-> $stable(result_q));
  // R5: word results carry bit 31 through the upper half.
  p_word_sext_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    done_q && op_q == OP_WORD |-> result_q[XLEN-1:WLEN] == {PADW{result_q[WLEN-1]}});

endmodule

// File: tb/sim_mul64_unit.sv
`timescale 1ns/1ps
module sim_mul64_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op_i;
  logic [63:0] a_i, b_i;
  logic        busy, done;
  logic [63:0] result;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    checking = 1'b0;
  string cur_tag = "R1";

  // model state
  bit          m_busy;
  bit          m_done;
  int          m_cnt;
  logic [63:0] m_res;
  logic [63:0] m_pend;
  string       m_tag = "R1";

  always #5 clk = ~clk;

  mul64_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .a(a_i), .b(b_i),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [63:0] ref_calc(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] ea, eb, p;
    logic [31:0]  w;
    case (op)
      3'd1: begin ea = {{64{a[63]}}, a}; eb = {{64{b[63]}}, b}; p = ea * eb; return p[127:64]; end
      3'd2: begin ea = {{64{a[63]}}, a}; eb = {64'd0, b};      p = ea * eb; return p[127:64]; end
      3'd3: begin ea = {64'd0, a};       eb = {64'd0, b};      p = ea * eb; return p[127:64]; end
      3'd4: begin w = a[31:0] * b[31:0]; return {{32{w[31]}}, w}; end
      default: return a * b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: accept when idle, count 64 edges, pulse done.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 64;
        m_pend = ref_calc(op_i, a_i, b_i);
        m_tag  = (cur_tag == "") ? tag_of(op_i) : cur_tag;
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (checking) begin
      chk(busy == m_busy, "R7", "busy", {63'd0, busy}, {63'd0, m_busy});
      chk(done == m_done, "R7", "done", {63'd0, done}, {63'd0, m_done});
      if (m_done) chk(result == m_res, m_tag, "result at done", result, m_res);
      else        chk(result == m_res, "R8", "held result", result, m_res);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clk);
    cur_tag = tag; start = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start = 1'b0;
    repeat (66) @(negedge clk);
  endtask

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] va [10];
    logic [63:0] vb [10];
    rst_n = 1'b0; start = 1'b0; op_i = 3'd0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(busy == 1'b0, "R8", "busy in reset", {63'd0, busy}, 64'd0);
    chk(done == 1'b0, "R8", "done in reset", {63'd0, done}, 64'd0);
    chk(result == '0, "R8", "result in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    va[0] = MINV; vb[0] = MINV;
    va[1] = MINV; vb[1] = NEG1;
    va[2] = NEG1; vb[2] = NEG1;
    va[3] = NEG1; vb[3] = MINV;
    va[4] = 64'd0; vb[4] = NEG1;
    va[5] = 64'd1; vb[5] = MINV;
    va[6] = MAXV; vb[6] = MAXV;
    va[7] = 64'hDEAD_BEEF_0123_4567; vb[7] = 64'hFEDC_BA98_7654_3210;
    va[8] = 64'h1234_5678_9ABC_DEF0; vb[8] = 64'h8765_4321_0FED_CBA9;
    va[9] = 64'hFFFF_FFFF_0001_0000; vb[9] = 64'h1234_5678_0000_8000;

    for (int o = 0; o < 5; o++)
      for (int i = 0; i < 10; i++)
        issue(3'(o), va[i], vb[i], tag_of(3'(o)));

    for (int i = 0; i < 6; i++)
      issue(3'(o_rand(i)), {$urandom, $urandom}, {$urandom, $urandom}, "");

    // R5: positive word product and upper-bit junk
    issue(3'd4, 64'hABCD_0000_0000_0003, 64'h5555_0000_0000_0007, "R5");
    // R9: unused codes act as the low-half product
    issue(3'd5, va[7], vb[7], "R9");
    issue(3'd7, MINV, NEG1, "R9");

    // R6: start pulse mid-run with different operands is ignored
    @(negedge clk);
    cur_tag = "R6"; start = 1'b1; op_i = 3'd1; a_i = va[7]; b_i = vb[7];
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; op_i = 3'd3; a_i = NEG1; b_i = NEG1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);

    // R6: start held high, new operands every cycle, back-to-back runs
    for (int c = 0; c < 200; c++) begin
      start = 1'b1; op_i = 3'(c % 5); a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
      @(negedge clk);
    end
    start = 1'b0;
    repeat (70) @(negedge clk);

    checking = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic int o_rand(input int i);
    return (i * 3 + 1) % 5;
  endfunction

endmodule